// File: doc/BRIEF.md
# Replicated Multi-Read Register File

This block is a small register file that serves many read ports at a fixed latency. It does not add read ports to a single array. Instead it keeps several identical copies of the whole storage. Every copy has one write port per writer, and every write is broadcast to all copies, so the copies stay in lockstep. The read ports are split evenly across the copies, and each port reads its own copy combinationally. Nothing in the block arbitrates or stalls.

Two writers can update the file in the same cycle. When both target the same entry, the higher-numbered write port wins. A write lands on the rising clock edge. All read ports see the new value from that edge on, which means a read issued in the cycle after the write returns it.

The reset input is asserted asynchronously and active low. Its release is synchronised inside the block through two flops. While reset is applied, every entry of every copy is zero.

Top module: `rfr_regfile`

## Requirements
- R1: While reset is in force, and after it is released with no writes since, every read port returns zero for every address.
- R2: Each read port returns the addressed entry combinationally, in the same cycle the address is applied, with no clock edge needed.
- R3: A write with its enable high on a rising edge is not visible before that edge, and is visible on all four read ports immediately after it.
- R4: The two write ports can update two different entries on the same edge, and both values are stored.
- R5: When both write ports target the same entry on the same edge, the value from write port 1 (the higher-numbered port) is stored.
- R6: An entry that no enabled write port addresses on an edge keeps its value.
- R7: Read ports 0 and 1 are served by copy 0, and read ports 2 and 3 by copy 1. Any read ports given the same address return identical data.
- R8: While a write port's enable is low, its address and data have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| wr_en | input | NWR (2) | Per write port enable, bit p for port p |
| wr_addr | input | NWR*AW (10) | Write addresses, port p in bits [p*AW +: AW] |
| wr_data | input | NWR*DW (64) | Write data, port p in bits [p*DW +: DW] |
| rd_addr | input | NRD*AW (20) | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | NRD*DW (128) | Read data, port r in bits [r*DW +: DW] |

## Verification
The bench builds the block with its default values: 32 entries of 32 bits, two write ports, two copies and four read ports. At this size, full sweeps over every address are cheap. Each read sweep places the four ports on four different addresses, so both copies are compared against the bench's own arithmetic model over the whole array. The bench also drives every address as a same-entry collision between the two write ports, which checks the priority rule at every location. A pass with all four ports on one address checks that the copies agree entry by entry.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  // Copy that serves a given read port, with ports split evenly in order.
  function automatic int copy_of_port(input int port, input int ports_per_copy);
    return port / ports_per_copy;
  endfunction
endpackage

// File: rtl/rfr_wr_resolve.sv
// Turns the write ports into per-entry enables and data.
// Later ports in the loop override earlier ones, so the highest port wins.
module rfr_wr_resolve #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int NWR   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [NWR-1:0]      wr_en,
  input  logic [NWR*AW-1:0]   wr_addr,
  input  logic [NWR*DW-1:0]   wr_data,
  output logic [DEPTH-1:0]    ent_we,
  output logic [DEPTH*DW-1:0] ent_wd
);
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      ent_we[e]          = 1'b0;
      ent_wd[e*DW +: DW] = '0;
      for (int p = 0; p < NWR; p++) begin
        if (wr_en[p] && (wr_addr[p*AW +: AW] == AW'(e))) begin
          ent_we[e]          = 1'b1;
          ent_wd[e*DW +: DW] = wr_data[p*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/rfr_replica.sv
// One full copy of the storage: receives every write, serves NRPC readers.
module rfr_replica #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int NWR   = 2,
  parameter int NRPC  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NWR-1:0]       wr_en,
  input  logic [NWR*AW-1:0]    wr_addr,
  input  logic [NWR*DW-1:0]    wr_data,
  input  logic [NRPC*AW-1:0]   rd_addr,
  output logic [NRPC*DW-1:0]   rd_data
);
  logic [DEPTH-1:0]    ent_we;
  logic [DEPTH*DW-1:0] ent_wd;
  logic [DW-1:0]       mem_q [DEPTH];
  logic [DW-1:0]       mem_d [DEPTH];

  rfr_wr_resolve #(.DW(DW), .DEPTH(DEPTH), .NWR(NWR)) u_resolve (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ent_we  (ent_we),
    .ent_wd  (ent_wd)
  );

  // next-state
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      mem_d[e] = ent_we[e] ? ent_wd[e*DW +: DW] : mem_q[e];
    end
  end

  // registers with explicit per-entry clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (ent_we[e]) mem_q[e] <= mem_d[e];
      end
    end
  end

  // combinational read ports
  for (genvar r = 0; r < NRPC; r++) begin : g_rd
    assign rd_data[r*DW +: DW] = mem_q[rd_addr[r*AW +: AW]];
  end

  // R6: an entry with no resolved write keeps its value
  for (genvar e = 0; e < DEPTH; e++) begin : g_hold_chk
    a_r6_entry_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_we[e] |=> $stable(mem_q[e]));
  end

  // R5: the highest write port always lands its data
  a_r5_top_port_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[NWR-1] |=> (mem_q[$past(wr_addr[(NWR-1)*AW +: AW])] == $past(wr_data[(NWR-1)*DW +: DW])));
endmodule

// File: rtl/rfr_regfile.sv
module rfr_regfile #(
  parameter int DW     = 32,
  parameter int DEPTH  = 32,
  parameter int NWR    = 2,
  parameter int NCOPY  = 2,
  parameter int NRD    = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int NRPC  = NRD / NCOPY
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NWR-1:0]     wr_en,
  input  logic [NWR*AW-1:0]  wr_addr,
  input  logic [NWR*DW-1:0]  wr_data,
  input  logic [NRD*AW-1:0]  rd_addr,
  output logic [NRD*DW-1:0]  rd_data
);
  import rfr_pkg::*;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    rfr_replica #(.DW(DW), .DEPTH(DEPTH), .NWR(NWR), .NRPC(NRPC)) u_copy (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr[c*NRPC*AW +: NRPC*AW]),
      .rd_data (rd_data[c*NRPC*DW +: NRPC*DW])
    );
  end

  // R7: port 0 (copy 0) and the first port of every other copy agree on equal addresses
  for (genvar c = 1; c < NCOPY; c++) begin : g_agree_chk
    localparam int RP = c * NRPC;
    a_r7_copies_agree: assert property (@(posedge clk) disable iff (!rst_int_n)
      (copy_of_port(RP, NRPC) == c) && (rd_addr[0 +: AW] == rd_addr[RP*AW +: AW])
        |-> (rd_data[0 +: DW] == rd_data[RP*DW +: DW]));
  end

  // R1: while the synchronised reset is still held, all reads return zero
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> (rd_data == '0));
endmodule

// File: tb/sim_rfr_regfile.sv
module sim_rfr_regfile;
  localparam int DW = 32, DEPTH = 32, NWR = 2, NCOPY = 2, NRD = 4;
  localparam int AW = $clog2(DEPTH);

  logic               clk;
  logic               rst_n;
  logic [NWR-1:0]     wr_en;
  logic [NWR*AW-1:0]  wr_addr;
  logic [NWR*DW-1:0]  wr_data;
  logic [NRD*AW-1:0]  rd_addr;
  logic [NRD*DW-1:0]  rd_data;

  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rfr_regfile #(.DW(DW), .DEPTH(DEPTH), .NWR(NWR), .NCOPY(NCOPY), .NRD(NRD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return (DW'(a) * 32'h0101_0101) ^ (DW'(salt) * 32'h9E37_79B9);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // four ports on four different addresses per step; covers both copies
  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      for (int k = 0; k < NRD; k++) rd_addr[k*AW +: AW] = AW'((a + k*8) % DEPTH);
      #1;
      for (int k = 0; k < NRD; k++)
        chk(req, rd_data[k*DW +: DW], model[(a + k*8) % DEPTH]);
    end
  endtask

  // drive at a negedge, write at the posedge, return at the next negedge
  task automatic wr2(input logic e0, input int a0, input logic [DW-1:0] d0,
                     input logic e1, input int a1, input logic [DW-1:0] d1);
    wr_en = {e1, e0};
    wr_addr = {AW'(a1), AW'(a0)};
    wr_data = {d1, d0};
    @(posedge clk);
    @(negedge clk);
    wr_en = '0;
    if (e0) model[a0] = d0;
    if (e1) model[a1] = d1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    sweep("R1");                        // zero while reset asserted
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sweep("R1");                        // zero after release

    // R4: both ports write distinct entries each edge; R2 reads via sweep
    for (int i = 0; i < DEPTH/2; i++)
      wr2(1'b1, 2*i, pat(2*i, 1), 1'b1, 2*i+1, pat(2*i+1, 1));
    sweep("R4");
    sweep("R2");

    // R3: not visible before the edge, visible on all ports just after
    for (int a = 0; a < DEPTH; a += 5) begin
      for (int k = 0; k < NRD; k++) rd_addr[k*AW +: AW] = AW'(a);
      wr_en = 2'b01; wr_addr = {AW'(0), AW'(a)}; wr_data = {DW'(0), pat(a, 7)};
      #1;
      chk("R3", rd_data[0 +: DW], model[a]);
      @(posedge clk); #1;
      for (int k = 0; k < NRD; k++) chk("R3", rd_data[k*DW +: DW], pat(a, 7));
      @(negedge clk);
      wr_en = '0;
      model[a] = pat(a, 7);
    end

    // R5: same-entry collision at every address, port 1 must win
    for (int a = 0; a < DEPTH; a++)
      wr2(1'b1, a, pat(a, 11), 1'b1, a, pat(a, 13));
    for (int a = 0; a < DEPTH; a++) chk("R5", model[a], pat(a, 13));
    sweep("R5");

    // R8: disabled ports with live address and data change nothing
    wr_en = '0;
    for (int a = 0; a < DEPTH; a++) begin
      wr_addr = {AW'(a), AW'(DEPTH-1-a)};
      wr_data = {pat(a, 21), pat(a, 22)};
      @(posedge clk);
    end
    @(negedge clk);
    sweep("R8");

    // R6: single write by port 0 only; all other entries untouched
    wr2(1'b1, 9, pat(9, 30), 1'b0, 20, pat(20, 31));
    sweep("R6");

    // R7: all ports on one address return identical data
    for (int a = 0; a < DEPTH; a++) begin
      for (int k = 0; k < NRD; k++) rd_addr[k*AW +: AW] = AW'(a);
      #1;
      for (int k = 1; k < NRD; k++) chk("R7", rd_data[k*DW +: DW], rd_data[0 +: DW]);
      chk("R7", rd_data[2*DW +: DW], model[a]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule